// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This unit captures sixteen interrupt request lines. Each line has its own trigger mode, edge or level, set through byte-wide registers on a small host read/write bus. The same bus also sets a per-line mask. Inputs first pass through a synchronizer. A line in edge mode latches a request on a rising edge. A line in level mode asserts its request for as long as its input stays high. The unit drives a registered interrupt output and a registered index for the highest-priority unmasked request, where the lowest line number wins.

Some lines have a fixed role and can only trigger on edges, so their mode bits are tied to zero. The unit also models a real hazard of the edge detector. If a line is high while its mode is switched from level to edge, the detector sees a rising edge and latches a request. This happens even when the line is masked, and the request is delivered once the mask is cleared. An acknowledge input clears one line's latch. A re-initialize pulse clears every latch, which is how software removes such spurious requests.

Top module: `trig_irq_capture`

## Requirements
- R1: The bus registers sit at fixed addresses. Address 0 holds the mode bits of lines 0–7 and address 1 holds lines 8–15. Addresses 2 and 3 hold the mask bits of lines 0–7 and 8–15. In every register, bit k maps to the k-th line of that group.
- R2: A mode bit of 0 makes its line edge-triggered and a 1 makes it level-triggered. A mask bit of 1 blocks the line from the outputs.
- R3: A synchronous reset clears both mode registers to 00h and sets both mask registers to FFh.
- R4: The mode bits of lines 0, 1, 2, 8 and 13 always read 0, whatever is written. Writing FFh reads back F8h at address 0 and DEh at address 1.
- R5: In edge mode, a 0-to-1 change on an input latches a request three clocks after the input changes. The request stays latched after the input falls.
- R6: In level mode, the request follows the synchronized input. It drops when the input goes low and stays present through an acknowledge while the input stays high.
- R7: If a line's input is high when its mode bit goes from 1 to 0, a request is latched on that line.
- R8: Such a request is latched even while the line is masked, and it appears at the outputs once the mask bit is cleared.
- R9: A re-initialize pulse clears every latched edge request, spurious ones included.
- R10: The interrupt output and the pending-valid flag are registered. Both are high exactly when an unmasked request exists. The pending index gives the lowest-numbered unmasked request.
- R11: An acknowledge clears only the latch of the line named by the acknowledge index.
- R12: Read data appears on the clock after a read cycle and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Asynchronous request inputs |
| bus_valid | input | 1 | Host access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 4 | Line being acknowledged |
| reinit | input | 1 | Clear all latched edge requests |
| irq_out | output | 1 | Any unmasked request present |
| pend_valid | output | 1 | Pending index is meaningful |
| pend_idx | output | 4 | Lowest-numbered unmasked request |

## Verification
The bench drives several kinds of input pulse. A single-cycle pulse on an edge line shows that the latch holds after the input falls. A held level input, acknowledged partway through, shows that level requests follow the input and are not cleared by an acknowledge. Two edges arriving together on lines 4 and 9 show the priority order, and acknowledging the winner shows that the other line's latch survives. A level line that is held high, masked, and then switched to edge mode shows the spurious latch; it is then unmasked to deliver it, and a re-initialize pulse clears it.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;
  // register groups on the host bus; offsets are decoded by trig_irq_regs
  typedef enum logic [1:0] {
    RA_MODE_LO = 2'd0,
    RA_MODE_HI = 2'd1,
    RA_MASK_LO = 2'd2,
    RA_MASK_HI = 2'd3
  } reg_addr_e;

  localparam logic [15:0] DEFAULT_EDGE_ONLY = 16'h2107;
endpackage

// File: rtl/trig_irq_sync.sv
module trig_irq_sync #(
  parameter int N      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] synced
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign synced = stg[STAGES-1];
endmodule

// File: rtl/trig_irq_regs.sv
module trig_irq_regs #(
  parameter int              N         = 16,
  parameter int              W         = 8,
  parameter logic [N-1:0]    EDGE_ONLY = trig_irq_pkg::DEFAULT_EDGE_ONLY,
  localparam int             NB        = N / W,
  localparam int             AW        = $clog2(2 * NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic [N-1:0]  mode,
  output logic [N-1:0]  mask
);
  logic [N-1:0]   mode_q, mask_q;
  logic [2*N-1:0] all_regs;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[b*W +: W] <= '0;
        mask_q[b*W +: W] <= '1;
      end else if (bus_valid && bus_we) begin
        if (bus_addr == AW'(b))
          mode_q[b*W +: W] <= bus_wdata & ~EDGE_ONLY[b*W +: W];
        if (bus_addr == AW'(NB + b))
          mask_q[b*W +: W] <= bus_wdata;
      end
    end
  end

  assign all_regs = {mask_q, mode_q};

  always_ff @(posedge clk) begin
    if (rst)                       bus_rdata <= '0;
    else if (bus_valid && !bus_we) bus_rdata <= all_regs[int'(bus_addr)*W +: W];
  end

  assign mode = mode_q;
  assign mask = mask_q;

  // R4
  forced_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q & EDGE_ONLY) == '0);

  // R3
  reset_mask_chk: assert property (@(posedge clk)
    rst |=> (mask_q == '1 && mode_q == '0));
endmodule

// File: rtl/trig_irq_core.sv
module trig_irq_core #(
  parameter int  N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  sync_in,
  input  logic [N-1:0]  mode,
  input  logic [N-1:0]  mask,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_idx,
  input  logic          reinit,
  output logic          irq_out,
  output logic          pend_valid,
  output logic [IW-1:0] pend_idx
);
  logic [N-1:0] prev_q;     // edge reference, held low while a line is level
  logic [N-1:0] edge_lat;
  logic [N-1:0] ack_hot, rise, req, eff;
  logic [IW-1:0] win;

  always_comb begin
    ack_hot = '0;
    if (ack_valid) ack_hot[ack_idx] = 1'b1;
  end

  assign rise = sync_in & ~prev_q & ~mode;
  assign req  = edge_lat | (mode & sync_in);
  assign eff  = req & ~mask;

  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--)
      if (eff[i]) win = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= '0;
      edge_lat   <= '0;
      irq_out    <= 1'b0;
      pend_valid <= 1'b0;
      pend_idx   <= '0;
    end else begin
      prev_q     <= sync_in & ~mode;
      edge_lat   <= reinit ? '0 : (((edge_lat & ~ack_hot) | rise) & ~mode);
      irq_out    <= |eff;
      pend_valid <= |eff;
      pend_idx   <= win;
    end
  end

  // R9
  reinit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    reinit |=> (edge_lat == '0));

  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!reinit && !ack_valid && mode == '0) |=> ((edge_lat & $past(edge_lat)) == $past(edge_lat)));

  // R10
  pend_irq_agree_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out == pend_valid);

  // R10
  idx_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && $stable(mask)) |-> !mask[pend_idx]);
endmodule

// File: rtl/trig_irq_capture.sv
module trig_irq_capture #(
  parameter int           N           = 16,
  parameter int           W           = 8,
  parameter int           SYNC_STAGES = 2,
  parameter logic [N-1:0] EDGE_ONLY   = trig_irq_pkg::DEFAULT_EDGE_ONLY,
  localparam int          AW          = $clog2(2 * (N / W)),
  localparam int          IW          = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic          bus_valid,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_idx,
  input  logic          reinit,
  output logic          irq_out,
  output logic          pend_valid,
  output logic [IW-1:0] pend_idx
);
  logic [N-1:0] synced, mode, mask;

  trig_irq_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw(irq_in), .synced(synced)
  );

  trig_irq_regs #(.N(N), .W(W), .EDGE_ONLY(EDGE_ONLY)) u_regs (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode(mode), .mask(mask)
  );

  trig_irq_core #(.N(N)) u_core (
    .clk(clk), .rst(rst), .sync_in(synced), .mode(mode), .mask(mask),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .reinit(reinit),
    .irq_out(irq_out), .pend_valid(pend_valid), .pend_idx(pend_idx)
  );
endmodule

// File: tb/trig_irq_capture_tb.sv
module trig_irq_capture_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_idx = '0;
  logic        reinit = 1'b0;
  logic        irq_out, pend_valid;
  logic [3:0]  pend_idx;

  int checks = 0, fails = 0;
  string cur_req = "R3";
  bit done = 0;

  always #2.5 clk = ~clk;

  trig_irq_capture u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .reinit(reinit),
    .irq_out(irq_out), .pend_valid(pend_valid), .pend_idx(pend_idx)
  );

  // behavioural reference: per-line integers, advanced once per rising edge
  int m_s1[16], m_s2[16], m_ref[16], m_lat[16], m_mode[16], m_mask[16];
  int m_irq, m_pv, m_pidx, m_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_ref[i] = 0; m_lat[i] = 0;
        m_mode[i] = 0; m_mask[i] = 1;
      end
      m_irq = 0; m_pv = 0; m_pidx = 0; m_rd = 0;
    end else begin
      int any, low;
      any = 0; low = 0;
      for (int i = 15; i >= 0; i--) begin
        if ((m_lat[i] || (m_mode[i] && m_s2[i])) && !m_mask[i]) begin
          any = 1; low = i;
        end
      end
      m_irq = any; m_pv = any; m_pidx = low;
      for (int i = 0; i < 16; i++) begin
        if (reinit) m_lat[i] = 0;
        else begin
          if (ack_valid && int'(ack_idx) == i) m_lat[i] = 0;
          if (!m_mode[i] && m_s2[i] && !m_ref[i]) m_lat[i] = 1;
          if (m_mode[i]) m_lat[i] = 0;
        end
        m_ref[i] = m_mode[i] ? 0 : m_s2[i];
        m_s2[i] = m_s1[i];
        m_s1[i] = int'(irq_in[i]);
      end
      if (bus_valid && !bus_we) begin
        m_rd = 0;
        for (int k = 0; k < 8; k++) begin
          int ln;
          ln = (int'(bus_addr) % 2) * 8 + k;
          if (bus_addr < 2 ? m_mode[ln] != 0 : m_mask[ln] != 0) m_rd += (1 << k);
        end
      end
      if (bus_valid && bus_we) begin
        for (int k = 0; k < 8; k++) begin
          int ln;
          ln = (int'(bus_addr) % 2) * 8 + k;
          if (bus_addr < 2) m_mode[ln] = (bus_wdata[k] && !(ln inside {0, 1, 2, 8, 13})) ? 1 : 0;
          else              m_mask[ln] = bus_wdata[k] ? 1 : 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "irq_out", int'(irq_out), m_irq);
      chk("R10", "pend_valid", int'(pend_valid), m_pv);
      if (m_pv != 0) chk("R10", "pend_idx", int'(pend_idx), m_pidx);
      chk("R12", "bus_rdata", int'(bus_rdata), m_rd);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_valid = 1; bus_we = 1; bus_addr = 2'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_valid = 0; bus_we = 0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk);
    bus_valid = 1; bus_we = 0; bus_addr = 2'(a);
    @(negedge clk);
    bus_valid = 0;
    chk(tag, "register read", int'(bus_rdata), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(input int line);
    @(negedge clk);
    ack_valid = 1; ack_idx = 4'(line);
    @(negedge clk);
    ack_valid = 0;
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        cur_req = "R3";
        chk("R3", "irq_out after reset", int'(irq_out), 0);
        rd(0, 8'h00, "R3"); rd(1, 8'h00, "R3");
        rd(2, 8'hFF, "R3"); rd(3, 8'hFF, "R3");
        cur_req = "R4";
        wr(0, 8'hFF); wr(1, 8'hFF);
        rd(0, 8'hF8, "R4"); rd(1, 8'hDE, "R4");
        cur_req = "R1";
        wr(0, 8'h00); wr(1, 8'h00);
        wr(2, 8'h00); wr(3, 8'h00);
        rd(2, 8'h00, "R1");
        // R5: one-cycle pulse on line 5 is held
        cur_req = "R5";
        @(negedge clk); irq_in[5] = 1;
        @(negedge clk); irq_in[5] = 0;
        idle(6);
        chk("R5", "edge held after input fell", int'(irq_out), 1);
        chk("R5", "edge line index", int'(pend_idx), 5);
        cur_req = "R11";
        ack(5); idle(2);
        chk("R11", "ack clears line 5", int'(irq_out), 0);
        // R6: level line 3
        cur_req = "R6";
        wr(0, 8'h08);
        irq_in[3] = 1; idle(6);
        ack(3); idle(3);
        chk("R6", "level survives ack", int'(irq_out), 1);
        irq_in[3] = 0; idle(5);
        chk("R6", "level drops with input", int'(irq_out), 0);
        wr(0, 8'h00);
        // R10 / R11: priority between lines 4 and 9
        cur_req = "R10";
        @(negedge clk); irq_in[4] = 1; irq_in[9] = 1;
        @(negedge clk); irq_in[4] = 0; irq_in[9] = 0;
        idle(5);
        chk("R10", "lowest line wins", int'(pend_idx), 4);
        cur_req = "R11";
        ack(4); idle(2);
        chk("R11", "other latch kept", int'(pend_idx), 9);
        ack(9); idle(2);
        // R7/R8: spurious request on masked line 6
        cur_req = "R7";
        wr(2, 8'h40);
        wr(0, 8'h40);
        irq_in[6] = 1; idle(5);
        wr(0, 8'h00); idle(4);
        chk("R8", "masked spurious hidden", int'(irq_out), 0);
        irq_in[6] = 0; idle(3);
        cur_req = "R8";
        wr(2, 8'h00); idle(2);
        chk("R8", "spurious delivered on unmask", int'(pend_idx), 6);
        chk("R7", "spurious latched", int'(irq_out), 1);
        // R9: reinit clears it
        cur_req = "R9";
        @(negedge clk); reinit = 1;
        @(negedge clk); reinit = 0;
        idle(2);
        chk("R9", "reinit cleared latch", int'(irq_out), 0);
        // R2: mask bit blocks an edge, unmask shows it
        cur_req = "R2";
        wr(3, 8'h80);
        @(negedge clk); irq_in[15] = 1;
        @(negedge clk); irq_in[15] = 0;
        idle(5);
        chk("R2", "masked line hidden", int'(irq_out), 0);
        wr(3, 8'h00); idle(2);
        chk("R2", "line 15 after unmask", int'(pend_idx), 15);
        idle(3);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule